// File: doc/BRIEF.md
# Bridge Burst Read Buffer Controller

This block converts read requests from a fast big-endian system bus into read transactions on a slower 32-bit PCI-style initiator. It keeps the returned 32-bit data phases in a one-line word buffer. The requester's address phase stays open until every requested word has been captured, so each burst looks atomic to the requester. A request is taken when `req_valid` is high in an idle cycle. When the block accepts the final data phase it pulses `req_ack`, and the filled words can then be read on `buf_data` and `buf_valid`.

A memory burst covers one 32-byte line and takes eight PCI data phases. Every other read takes two data phases, aligned to an 8-byte boundary. If the target disconnects early, the block asks for the bus again. Once granted, it starts a new transaction at the first word it has not yet received.

The block may be waiting for a grant when another PCI master starts an access to local memory. In that case it pulses a retry toward the requester and throws away the partial fill. It keeps requesting the bus, then restarts the line from its first word and finishes with an acknowledge.

Top module: `bridge_rdbuf`

## Requirements
- R1: `req_kind` is decoded as 0 memory, 1 I/O, 2 configuration, 3 interrupt acknowledge. `txn_cmd` carries 4'b0110, 4'b0010, 4'b1010 and 4'b0000 for these kinds, in that order.
- R2: `bus_req` is high from the cycle after a request is accepted until a grant is taken. `txn_start` pulses for one cycle in the cycle after `bus_gnt` is sampled while requesting.
- R3: A memory request with `req_burst` = 1 uses 8 data phases (`txn_phases` = 8). Any other request uses 2 data phases starting at an 8-byte-aligned word, and `req_burst` is ignored for non-memory kinds.
- R4: `txn_addr[4:2]` holds the word index of the first phase. `txn_addr[1:0]` is 2'b10 (wrap mode) when the transfer is an 8-phase burst and that word index is nonzero. Otherwise it is 2'b00. The upper bits follow the request address.
- R5: Each captured data phase is stored in buffer slot i, where i is the phase's word index, at bits [32*i+31:32*i] of `buf_data`. The same phase sets bit i of `buf_valid`. Acceptance of a new request clears `buf_valid`.
- R6: `req_ack` is a one-cycle pulse in the cycle after the final requested phase is captured. It never appears earlier, and never together with `req_retry`.
- R7: `dph_disc` high in a data cycle (with or without data) before the final phase returns the block to requesting the bus. The next transaction starts at the first uncaptured word with the remaining phase count.
- R8: `inb_local_req` high while the block waits for a grant produces a one-cycle `req_retry`. `buf_valid` reads all-zero in that same cycle, and `bus_req` stays high.
- R9: After a retry, the next transaction restarts at the first word of the request with the full phase count. It ends with `req_ack`.
- R10: At most one retry is issued per grant wait. If `inb_local_req` and `bus_gnt` are both high in the same wait cycle, the retry wins and no transaction starts in that cycle.
- R11: During reset all outputs are zero.
- R12: `req_valid` is ignored while a request is in progress: later transactions keep the original address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | System-bus read request strobe |
| req_addr | input | 32 | Request byte address |
| req_kind | input | 2 | Request kind (see R1) |
| req_burst | input | 1 | Line burst request |
| req_ack | output | 1 | Address-phase acknowledge pulse |
| req_retry | output | 1 | Retry pulse to requester |
| bus_req | output | 1 | PCI bus request |
| bus_gnt | input | 1 | PCI bus grant |
| inb_local_req | input | 1 | Another master is accessing local memory |
| txn_start | output | 1 | Transaction launch pulse |
| txn_addr | output | 32 | Transaction address with mode bits |
| txn_cmd | output | 4 | PCI read command |
| txn_phases | output | 4 | Data phases requested |
| dph_valid | input | 1 | Data phase completed by target |
| dph_data | input | 32 | Data phase payload |
| dph_disc | input | 1 | Target disconnect |
| buf_valid | output | 8 | Per-word valid mask |
| buf_data | output | 256 | Buffered line, word i at [32*i+31:32*i] |

## Verification
The checker watches every cycle for these rules: launches follow a sampled grant, acknowledges follow a captured phase, retries and acknowledges are single-cycle pulses that never coincide, and a retry always sees an empty mask while the request is still raised. It also checks that launch fields stay legal. The bench scenarios are needed to show correct command decode, the wrap-mode address, the resume address after a disconnect, the word placement in the buffer, and the full restart after a retry. Those scenarios also show that a second request is ignored during a wait and that a grant loses to an inbound access in the same cycle.

// File: rtl/bf_pkg.sv
package bf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_DATA = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    K_MEM  = 2'd0,
    K_IO   = 2'd1,
    K_CFG  = 2'd2,
    K_IACK = 2'd3
  } rd_kind_e;

  // R1: command code driven for each request kind
  function automatic logic [3:0] read_cmd(input rd_kind_e k);
    case (k)
      K_MEM:   read_cmd = 4'b0110;
      K_IO:    read_cmd = 4'b0010;
      K_CFG:   read_cmd = 4'b1010;
      default: read_cmd = 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/bf_addr.sv
// Computes the word index, address and remaining phase count for the next launch.
module bf_addr #(
  parameter int AW         = 32,
  parameter int LINE_WORDS = 8,
  localparam int WIDX      = $clog2(LINE_WORDS),
  localparam int PW        = WIDX + 1
) (
  input  logic [AW-1:0]   base_addr,
  input  logic            burst_eff,
  input  logic [PW-1:0]   done,
  output logic [WIDX-1:0] cur_word,
  output logic [PW-1:0]   line_total,
  output logic [PW-1:0]   remaining,
  output logic [AW-1:0]   phase_addr
);

  logic [WIDX-1:0] start_word;

  always_comb begin
    start_word = base_addr[WIDX+1:2];
    // R3: two-phase reads begin on an even word
    if (!burst_eff) start_word[0] = 1'b0;
    cur_word   = start_word + done[WIDX-1:0];
    line_total = burst_eff ? PW'(LINE_WORDS) : PW'(2);
    remaining  = line_total - done;
    phase_addr = base_addr;
    phase_addr[WIDX+1:2] = cur_word;
    // R4: wrap mode when a burst begins away from word zero
    phase_addr[1:0] = (burst_eff && (cur_word != '0)) ? 2'b10 : 2'b00;
  end

endmodule

// File: rtl/bf_buffer.sv
// Line buffer: one slot per word with its own valid bit.
module bf_buffer #(
  parameter int DW         = 32,
  parameter int LINE_WORDS = 8,
  localparam int WIDX      = $clog2(LINE_WORDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [WIDX-1:0]          wr_idx,
  input  logic [DW-1:0]            wr_data,
  output logic [LINE_WORDS-1:0]    valid,
  output logic [DW*LINE_WORDS-1:0] data
);

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_slot
    logic          hit;
    logic          v_q;
    logic [DW-1:0] d_q;

    assign hit = wr_en && (wr_idx == WIDX'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        if (clr)      v_q <= 1'b0;
        else if (hit) v_q <= 1'b1;
        if (hit)      d_q <= wr_data;
      end
    end

    assign valid[g]            = v_q;
    assign data[g*DW +: DW]    = d_q;
  end

endmodule

// File: rtl/bf_seq.sv
// Request sequencer: arbitration wait, launch, phase counting, disconnect and retry.
module bf_seq
  import bf_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_WORDS = 8,
  localparam int WIDX      = $clog2(LINE_WORDS),
  localparam int PW        = WIDX + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_kind,
  input  logic          req_burst,
  input  logic          bus_gnt,
  input  logic          inb_local_req,
  input  logic          dph_valid,
  input  logic          dph_disc,
  input  logic [PW-1:0] line_total,
  input  logic [PW-1:0] remaining,
  input  logic [AW-1:0] phase_addr,
  output logic [AW-1:0] base_addr,
  output logic          burst_eff,
  output logic [PW-1:0] done,
  output logic          bus_req,
  output logic          req_ack,
  output logic          req_retry,
  output logic          txn_start,
  output logic [AW-1:0] txn_addr,
  output logic [3:0]    txn_cmd,
  output logic [PW-1:0] txn_phases,
  output logic          buf_clr,
  output logic          buf_wr
);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] base_q;
  rd_kind_e      kind_q;
  logic          burst_q;
  logic [PW-1:0] done_q, done_d;
  logic          retried_q, retried_d;
  logic          ack_q, retry_q, start_q;
  logic [AW-1:0] taddr_q;
  logic [3:0]    tcmd_q;
  logic [PW-1:0] tph_q;

  logic accept, retry_fire, grant_take, beat, last;

  always_comb begin
    accept     = (state_q == ST_IDLE) && req_valid;
    // R10: inbound access outranks a grant; once per wait
    retry_fire = (state_q == ST_ARB) && inb_local_req && !retried_q;
    grant_take = (state_q == ST_ARB) && bus_gnt && !retry_fire;
    beat       = (state_q == ST_DATA) && dph_valid;
    last       = beat && ((done_q + PW'(1)) == line_total);
  end

  always_comb begin
    state_d   = state_q;
    done_d    = done_q;
    retried_d = retried_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d   = ST_ARB;
          done_d    = '0;
          retried_d = 1'b0;
        end
      end
      ST_ARB: begin
        if (retry_fire) begin
          done_d    = '0;
          retried_d = 1'b1;
        end else if (bus_gnt) begin
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (beat) done_d = done_q + PW'(1);
        if (last) begin
          state_d = ST_IDLE;
        end else if (dph_disc) begin
          state_d   = ST_ARB;
          retried_d = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      done_q    <= '0;
      retried_q <= 1'b0;
      ack_q     <= 1'b0;
      retry_q   <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      done_q    <= done_d;
      retried_q <= retried_d;
      ack_q     <= last;
      retry_q   <= retry_fire;
      start_q   <= grant_take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      kind_q  <= K_MEM;
      burst_q <= 1'b0;
    end else if (accept) begin
      base_q  <= req_addr;
      kind_q  <= rd_kind_e'(req_kind);
      burst_q <= req_burst && (rd_kind_e'(req_kind) == K_MEM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taddr_q <= '0;
      tcmd_q  <= '0;
      tph_q   <= '0;
    end else if (grant_take) begin
      taddr_q <= phase_addr;
      tcmd_q  <= read_cmd(kind_q);
      tph_q   <= remaining;
    end
  end

  assign base_addr  = base_q;
  assign burst_eff  = burst_q;
  assign done       = done_q;
  assign bus_req    = (state_q == ST_ARB);
  assign req_ack    = ack_q;
  assign req_retry  = retry_q;
  assign txn_start  = start_q;
  assign txn_addr   = taddr_q;
  assign txn_cmd    = tcmd_q;
  assign txn_phases = tph_q;
  assign buf_clr    = accept || retry_fire;
  assign buf_wr     = beat;

endmodule

// File: rtl/bridge_rdbuf.sv
module bridge_rdbuf #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LINE_WORDS = 8,
  localparam int WIDX      = $clog2(LINE_WORDS),
  localparam int PW        = WIDX + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [AW-1:0]            req_addr,
  input  logic [1:0]               req_kind,
  input  logic                     req_burst,
  output logic                     req_ack,
  output logic                     req_retry,
  output logic                     bus_req,
  input  logic                     bus_gnt,
  input  logic                     inb_local_req,
  output logic                     txn_start,
  output logic [AW-1:0]            txn_addr,
  output logic [3:0]               txn_cmd,
  output logic [PW-1:0]            txn_phases,
  input  logic                     dph_valid,
  input  logic [DW-1:0]            dph_data,
  input  logic                     dph_disc,
  output logic [LINE_WORDS-1:0]    buf_valid,
  output logic [DW*LINE_WORDS-1:0] buf_data
);

  logic [AW-1:0]   base_addr, phase_addr;
  logic            burst_eff, buf_clr, buf_wr;
  logic [PW-1:0]   done, line_total, remaining;
  logic [WIDX-1:0] cur_word;

  bf_seq #(.AW(AW), .LINE_WORDS(LINE_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind), .req_burst(req_burst),
    .bus_gnt(bus_gnt), .inb_local_req(inb_local_req),
    .dph_valid(dph_valid), .dph_disc(dph_disc),
    .line_total(line_total), .remaining(remaining), .phase_addr(phase_addr),
    .base_addr(base_addr), .burst_eff(burst_eff), .done(done),
    .bus_req(bus_req), .req_ack(req_ack), .req_retry(req_retry),
    .txn_start(txn_start), .txn_addr(txn_addr), .txn_cmd(txn_cmd), .txn_phases(txn_phases),
    .buf_clr(buf_clr), .buf_wr(buf_wr)
  );

  bf_addr #(.AW(AW), .LINE_WORDS(LINE_WORDS)) u_addr (
    .base_addr(base_addr), .burst_eff(burst_eff), .done(done),
    .cur_word(cur_word), .line_total(line_total), .remaining(remaining),
    .phase_addr(phase_addr)
  );

  bf_buffer #(.DW(DW), .LINE_WORDS(LINE_WORDS)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
    .wr_idx(cur_word), .wr_data(dph_data),
    .valid(buf_valid), .data(buf_data)
  );

endmodule

// File: rtl/bridge_rdbuf_chk.sv
module bridge_rdbuf_chk #(
  parameter int AW         = 32,
  parameter int LINE_WORDS = 8,
  localparam int PW        = $clog2(LINE_WORDS) + 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_req,
  input logic                  bus_gnt,
  input logic                  txn_start,
  input logic [AW-1:0]         txn_addr,
  input logic [PW-1:0]         txn_phases,
  input logic                  dph_valid,
  input logic                  req_ack,
  input logic                  req_retry,
  input logic [LINE_WORDS-1:0] buf_valid
);

  // R2
  launch_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |-> ($past(bus_gnt) && $past(bus_req)));

  // R3
  phase_count_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |-> ((txn_phases != '0) && (txn_phases <= PW'(LINE_WORDS))));

  // R4
  mode_bits_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |-> (txn_addr[0] == 1'b0));

  // R6
  ack_after_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> $past(dph_valid));

  // R6
  ack_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  // R6
  ack_retry_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ack && req_retry));

  // R8
  retry_empties_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_retry |-> ((buf_valid == '0) && bus_req));

  // R10
  retry_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_retry |=> !req_retry);

endmodule

bind bridge_rdbuf bridge_rdbuf_chk #(.AW(AW), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .txn_start(txn_start), .txn_addr(txn_addr), .txn_phases(txn_phases),
  .dph_valid(dph_valid), .req_ack(req_ack), .req_retry(req_retry),
  .buf_valid(buf_valid)
);

// File: tb/bridge_rdbuf_test.sv
module bridge_rdbuf_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic [31:0]  req_addr;
  logic [1:0]   req_kind;
  logic         req_burst;
  logic         req_ack, req_retry, bus_req;
  logic         bus_gnt, inb_local_req;
  logic         txn_start;
  logic [31:0]  txn_addr;
  logic [3:0]   txn_cmd;
  logic [3:0]   txn_phases;
  logic         dph_valid;
  logic [31:0]  dph_data;
  logic         dph_disc;
  logic [7:0]   buf_valid;
  logic [255:0] buf_data;

  int checks = 0;
  int failures = 0;

  bridge_rdbuf uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_burst(req_burst), .req_ack(req_ack), .req_retry(req_retry),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .inb_local_req(inb_local_req),
    .txn_start(txn_start), .txn_addr(txn_addr), .txn_cmd(txn_cmd), .txn_phases(txn_phases),
    .dph_valid(dph_valid), .dph_data(dph_data), .dph_disc(dph_disc),
    .buf_valid(buf_valid), .buf_data(buf_data)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  kind;
    logic        burst;
    logic [3:0]  disc;
    logic [3:0]  cmd;
    logic [31:0] a1;
    logic [3:0]  ph1;
    logic [31:0] a2;
    logic [3:0]  ph2;
    logic [7:0]  mask;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h1000_0000, 2'd0, 1'b1, 4'd0, 4'h6, 32'h1000_0000, 4'd8, 32'h0,         4'd0, 8'hFF},
    '{32'h1000_0048, 2'd0, 1'b1, 4'd0, 4'h6, 32'h1000_004A, 4'd8, 32'h0,         4'd0, 8'hFF},
    '{32'h2000_0020, 2'd0, 1'b1, 4'd4, 4'h6, 32'h2000_0020, 4'd8, 32'h2000_0032, 4'd4, 8'hFF},
    '{32'h3000_0010, 2'd1, 1'b0, 4'd0, 4'h2, 32'h3000_0010, 4'd2, 32'h0,         4'd0, 8'h30},
    '{32'h0000_081C, 2'd2, 1'b0, 4'd0, 4'hA, 32'h0000_0818, 4'd2, 32'h0,         4'd0, 8'hC0},
    '{32'h0000_0000, 2'd3, 1'b1, 4'd0, 4'h0, 32'h0000_0000, 4'd2, 32'h0,         4'd0, 8'h03},
    '{32'h4000_0038, 2'd0, 1'b0, 4'd1, 4'h6, 32'h4000_0038, 4'd2, 32'h4000_003C, 4'd1, 8'hC0},
    '{32'h5000_001C, 2'd0, 1'b1, 4'd7, 4'h6, 32'h5000_001E, 4'd8, 32'h5000_001A, 4'd1, 8'hFF}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [7:0] tag, input logic [2:0] w);
    return {16'hC0DE, tag, 5'b0, w};
  endfunction

  task automatic wait_start(output logic seen);
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      tick();
      if (txn_start === 1'b1) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic feed(input logic [31:0] a, input int n, input logic disc_last, input logic [7:0] tag);
    for (int i = 0; i < n; i++) begin
      dph_valid = 1'b1;
      dph_data  = pat(tag, 3'(a[4:2] + 3'(i)));
      dph_disc  = disc_last && (i == n - 1);
      tick();
    end
    dph_valid = 1'b0;
    dph_disc  = 1'b0;
  endtask

  task automatic launch(input logic [31:0] addr, input logic [1:0] kind, input logic burst);
    req_valid = 1'b1;
    req_addr  = addr;
    req_kind  = kind;
    req_burst = burst;
    tick();
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic seen;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_kind = '0; req_burst = 1'b0;
    bus_gnt = 1'b0; inb_local_req = 1'b0; dph_valid = 1'b0; dph_data = '0; dph_disc = 1'b0;
    repeat (3) tick();
    // R11: outputs idle during reset
    chk("R11 reset outputs", {req_ack, req_retry, bus_req, txn_start, buf_valid, txn_phases}, '0);
    chk("R11 reset addr", {txn_addr, txn_cmd}, '0);
    rst_n = 1'b1;
    tick();

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int n1;
      t = VECS[v];
      launch(t.addr, t.kind, t.burst);
      chk("R2 bus_req raised", bus_req, 1'b1);
      bus_gnt = 1'b1;
      wait_start(seen);
      bus_gnt = 1'b0;
      chk("R2 launch seen", seen, 1'b1);
      chk("R1 command", txn_cmd, t.cmd);
      chk("R4 first address", txn_addr, t.a1);
      chk("R3 phase count", txn_phases, t.ph1);
      n1 = (t.disc != 0) ? int'(t.disc) : int'(t.ph1);
      feed(t.a1, n1, t.disc != 0, 8'(v));
      if (t.disc != 0) begin
        chk("R6 no ack after disconnect", req_ack, 1'b0);
        chk("R7 rerequest after disconnect", bus_req, 1'b1);
        bus_gnt = 1'b1;
        wait_start(seen);
        bus_gnt = 1'b0;
        chk("R7 resume launch", seen, 1'b1);
        chk("R7 resume address", txn_addr, t.a2);
        chk("R7 resume count", txn_phases, t.ph2);
        feed(t.a2, int'(t.ph2), 1'b0, 8'(v));
      end
      chk("R6 ack after final phase", req_ack, 1'b1);
      chk("R5 valid mask", buf_valid, t.mask);
      for (int w = 0; w < 8; w++)
        if (t.mask[w]) chk("R5 word contents", buf_data[w*32 +: 32], pat(8'(v), 3'(w)));
      tick();
      chk("R6 ack one cycle", req_ack, 1'b0);
    end

    // R8/R12: retry during first wait, stray request ignored
    launch(32'h6000_0000, 2'd0, 1'b1);
    req_valid = 1'b1; req_addr = 32'h7000_0040; req_kind = 2'd1; req_burst = 1'b0;
    tick();
    req_valid = 1'b0;
    chk("R2 no ack before grant", req_ack, 1'b0);
    inb_local_req = 1'b1;
    tick();
    chk("R8 retry pulse", req_retry, 1'b1);
    chk("R8 mask empty at retry", buf_valid, 8'h00);
    chk("R8 bus_req kept", bus_req, 1'b1);
    tick();
    chk("R10 single retry per wait", req_retry, 1'b0);
    tick();
    chk("R10 still single retry", req_retry, 1'b0);
    inb_local_req = 1'b0;
    bus_gnt = 1'b1;
    wait_start(seen);
    bus_gnt = 1'b0;
    chk("R12 original address kept", txn_addr, 32'h6000_0000);
    chk("R12 original command kept", txn_cmd, 4'h6);
    feed(32'h6000_0000, 3, 1'b1, 8'h40);
    chk("R7 partial mask", buf_valid, 8'h07);
    chk("R6 no ack on partial", req_ack, 1'b0);
    // R10: inbound and grant together, retry wins
    inb_local_req = 1'b1;
    bus_gnt = 1'b1;
    tick();
    chk("R10 retry beats grant", req_retry, 1'b1);
    chk("R10 no launch with retry", txn_start, 1'b0);
    chk("R8 partial fill discarded", buf_valid, 8'h00);
    inb_local_req = 1'b0;
    wait_start(seen);
    bus_gnt = 1'b0;
    chk("R9 restart launch", seen, 1'b1);
    chk("R9 restart address", txn_addr, 32'h6000_0000);
    chk("R9 restart count", txn_phases, 4'd8);
    feed(32'h6000_0000, 8, 1'b0, 8'h41);
    chk("R9 ack after restart", req_ack, 1'b1);
    chk("R9 full mask", buf_valid, 8'hFF);
    chk("R5 restart word 5", buf_data[5*32 +: 32], pat(8'h41, 3'd5));
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule